// File: doc/BRIEF.md
# Dual-Mode Timer with Watchdog Lock

This block is a 16-bit counter peripheral behind a small memory-mapped register bus. A slow tick of about 32.768 kHz reaches it as a one-cycle enable in the system clock domain. A prescaler divides this tick by 1, 16 or 256 before the counter advances. Four registers sit at word offsets: the load value, the live counter value, the control word, and a clear strobe. In normal mode the counter runs up or down. It either wraps at its terminal count or reloads from the load register, and each terminal pass raises a level interrupt.

When software sets the watchdog enable bit, the counter reloads from the load value and counts down. Software must write the clear register before the count runs out. Each such write reloads the count and starts a new timeout. If the count runs out, the block raises the interrupt or emits a one-cycle reset pulse, as a control bit selects. From the moment the watchdog is enabled, the load and control registers ignore writes until the block reset returns.

Top module: `gt_timer`

## Requirements
- R1: After reset the value register reads 0xFFFF, the load and control registers read 0, and both irq_o and wd_rst_o are low.
- R2: Word offsets select the registers: 0x0 is load (read/write), 0x4 is value (read-only), 0x8 is control, and 0xC is clear (write-only, reads 0). A load write also copies the written value into the counter. In control, bit 0 and bits 31:9 read as 0.
- R3: Control bits 3:2 set the prescale: 00 divides by 1, 01 by 16, 10 by 256, and 11 acts like 00. The counter moves one step per divided tick while bit 7 (enable) or bit 5 (watchdog) is set.
- R4: With bit 8 clear the counter counts down. A step taken at 0 is a terminal pass. In free-running mode (bit 6 clear) that step wraps the counter to 0xFFFF.
- R5: With bit 8 set the counter counts up, and a step taken at 0xFFFF is a terminal pass. With bit 6 set, a terminal pass reloads the counter from the load register. With bit 6 clear, an up count wraps to 0.
- R6: In normal mode a terminal pass sets irq_o. irq_o stays high until a write of any data to the clear register. If a pass and a clear write fall on the same cycle, the pass wins.
- R7: Writing control with bit 5 set loads the counter from the load register. From then on the counter counts down, whatever bits 8 and 6 hold. A step taken at 0 is an expiry, and the counter reloads from the load register, so a timeout lasts load+1 divided ticks.
- R8: On expiry with control bit 1 set, irq_o rises. With bit 1 clear, wd_rst_o pulses high for exactly one clock cycle and irq_o stays low.
- R9: In watchdog mode, a write to the clear register reloads the counter from the load register and restarts the prescaler, which prevents the pending expiry.
- R10: While bit 5 is set, writes to the load and control registers are ignored. Only the block reset clears bit 5.
- R11: Control bit 4 (secure clear) is stored and read back, and it has no effect on counting.
- R12: A control write that changes the prescale field, or the active state (bit 7 OR bit 5), clears the prescaler's phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle enable at the slow tick rate |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Byte offset within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Timer interrupt level |
| wd_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Some properties are checked on every cycle. The load and control registers stay stable while the watchdog lock is held. The reset pulse lasts one cycle and appears only when the reset option is selected. The interrupt holds until a clear write, and a service write reloads the counter. The counter steps down by one and reloads on a periodic terminal pass. The prescaler phase returns to zero after each step. Other behaviour shows only in the bench's scenarios: the exact length of each division ratio, the count of ticks to expiry, and the fact that a timely clear write prevents an expiry. The bench also shows that locked registers read back their old values, and that a prescale change restarts the tick phase.

// File: rtl/gt_pkg.sv
package gt_pkg;

    localparam int BUS_W = 32;
    localparam int PS_W  = 8;

    // control field, stored as word bits 8:1 in this order
    typedef struct packed {
        logic       up;
        logic       en;
        logic       periodic;
        logic       wd_en;
        logic       sec_clr;
        logic [1:0] presc;
        logic       irq_opt;
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_VALUE = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } reg_sel_e;

    function automatic logic [PS_W:0] presc_div(input logic [1:0] code);
        case (code)
            2'b01:   presc_div = (PS_W+1)'(16);
            2'b10:   presc_div = (PS_W+1)'(256);
            default: presc_div = (PS_W+1)'(1);
        endcase
    endfunction

endpackage

// File: rtl/gt_prescaler.sv
module gt_prescaler
    import gt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       active_i,
    input  logic       restart_i,
    input  logic [1:0] code_i,
    output logic       step_o
);
    logic [PS_W-1:0] cnt_q;
    logic [PS_W:0]   div_w;
    logic [PS_W-1:0] last_w;

    assign div_w  = presc_div(code_i);
    assign last_w = PS_W'(div_w - (PS_W+1)'(1));
    assign step_o = tick_i && active_i && !restart_i && (cnt_q == last_w);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (tick_i && active_i) begin
            cnt_q <= (cnt_q == last_w) ? '0 : cnt_q + PS_W'(1);
        end
    end

    // R3
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        step_o |=> (cnt_q == '0));

endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         up_i,
    input  logic         periodic_i,
    output logic [W-1:0] val_o,
    output logic         wrap_o
);
    logic [W-1:0] val_q;
    logic [W-1:0] term_w;

    assign term_w = up_i ? '1 : '0;
    assign wrap_o = step_i && !load_i && (val_q == term_w);
    assign val_o  = val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '1;
        end else if (load_i) begin
            val_q <= load_val_i;
        end else if (step_i) begin
            if (val_q == term_w) begin
                val_q <= periodic_i ? load_val_i : (up_i ? '0 : '1);
            end else begin
                val_q <= up_i ? val_q + W'(1) : val_q - W'(1);
            end
        end
    end

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && !up_i && val_q != '0) |=> (val_q == W'($past(val_q) - W'(1))));

    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_o && periodic_i) |=> (val_q == $past(load_val_i)));

endmodule

// File: rtl/gt_timer.sv
module gt_timer
    import gt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             bus_wr_i,
    input  logic [3:0]       bus_addr_i,
    input  logic [BUS_W-1:0] bus_wdata_i,
    output logic [BUS_W-1:0] bus_rdata_o,
    output logic             irq_o,
    output logic             wd_rst_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    reg_sel_e         sel_w;
    ctrl_t            ctrl_q, ctrl_new_w;
    logic [CNT_W-1:0] load_q, load_src_w, val_w;
    logic             locked_w, wr_load_w, wr_ctrl_w, wr_clr_w;
    logic             act_q_w, act_new_w, ps_restart_w, cnt_load_w;
    logic             step_w, wrap_w, irq_q, wd_rst_q;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata_i[BUS_W-1:CNT_W], bus_addr_i[1:0]};

    assign sel_w      = reg_sel_e'(bus_addr_i[3:2]);
    assign locked_w   = ctrl_q.wd_en;
    assign ctrl_new_w = ctrl_t'(bus_wdata_i[CTRL_W:1]);
    assign wr_load_w  = bus_wr_i && sel_w == REG_LOAD && !locked_w;
    assign wr_ctrl_w  = bus_wr_i && sel_w == REG_CTRL && !locked_w;
    assign wr_clr_w   = bus_wr_i && sel_w == REG_CLEAR;

    assign act_q_w    = ctrl_q.en || ctrl_q.wd_en;
    assign act_new_w  = ctrl_new_w.en || ctrl_new_w.wd_en;
    assign ps_restart_w = (wr_ctrl_w && (ctrl_new_w.presc != ctrl_q.presc || act_new_w != act_q_w))
                        || (wr_clr_w && locked_w);
    assign cnt_load_w = wr_load_w || (wr_ctrl_w && ctrl_new_w.wd_en) || (wr_clr_w && locked_w);
    assign load_src_w = wr_load_w ? bus_wdata_i[CNT_W-1:0] : load_q;

    gt_prescaler u_ps (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .active_i (act_q_w),
        .restart_i(ps_restart_w),
        .code_i   (ctrl_q.presc),
        .step_o   (step_w)
    );

    gt_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step_w),
        .load_i    (cnt_load_w),
        .load_val_i(load_src_w),
        .up_i      (ctrl_q.up && !locked_w),
        .periodic_i(ctrl_q.periodic || locked_w),
        .val_o     (val_w),
        .wrap_o    (wrap_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q   <= '0;
            ctrl_q   <= '0;
            irq_q    <= 1'b0;
            wd_rst_q <= 1'b0;
        end else begin
            if (wr_load_w) load_q <= bus_wdata_i[CNT_W-1:0];
            if (wr_ctrl_w) ctrl_q <= ctrl_new_w;
            if (wrap_w && (!locked_w || ctrl_q.irq_opt)) irq_q <= 1'b1;
            else if (wr_clr_w)                            irq_q <= 1'b0;
            wd_rst_q <= wrap_w && locked_w && !ctrl_q.irq_opt;
        end
    end

    always_comb begin
        case (sel_w)
            REG_LOAD:  bus_rdata_o = BUS_W'(load_q);
            REG_VALUE: bus_rdata_o = BUS_W'(val_w);
            REG_CTRL:  bus_rdata_o = BUS_W'({ctrl_q, 1'b0});
            default:   bus_rdata_o = '0;
        endcase
    end

    assign irq_o    = irq_q;
    assign wd_rst_o = wd_rst_q;

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.wd_en |=> ($stable(load_q) && $stable(ctrl_q)));

    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wd_rst_o |=> !wd_rst_o);

    // R8
    rst_option_chk: assert property (@(posedge clk) disable iff (rst)
        wd_rst_o |-> (ctrl_q.wd_en && !ctrl_q.irq_opt));

    // R9
    wd_service_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_clr_w && ctrl_q.wd_en) |=> (val_w == $past(load_q)));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !wr_clr_w) |=> irq_o);

endmodule

// File: tb/gt_timer_tb.sv
`timescale 1ns/1ps
module gt_timer_tb;

    localparam logic [3:0] A_LOAD = 4'h0;
    localparam logic [3:0] A_VAL  = 4'h4;
    localparam logic [3:0] A_CTRL = 4'h8;
    localparam logic [3:0] A_CLR  = 4'hC;

    localparam int NV = 5;
    localparam int V_CODE  [NV] = '{0, 1, 2, 3, 1};
    localparam int V_TICKS [NV] = '{5, 32, 256, 7, 15};
    localparam int V_EXP   [NV] = '{95, 98, 99, 93, 100};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wdr;
    int          total = 0;
    int          fails = 0;

    always #2.5 clk = ~clk;

    gt_timer u_dut (
        .clk(clk), .rst(rst), .tick_i(tick), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .wd_rst_o(wdr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr = 1'b0; tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++; fails++;
        $display("FAIL watchdog R1..all actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] r;
        do_reset();
        // R1 reset state
        bus_read(A_VAL, r);  chk("R1 value", r, 32'hFFFF);
        bus_read(A_LOAD, r); chk("R1 load", r, 0);
        bus_read(A_CTRL, r); chk("R1 ctrl", r, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 wd_rst", {31'b0, wdr}, 0);

        // R3 prescale table, down free-running from 100
        for (int v = 0; v < NV; v++) begin
            do_reset();
            bus_write(A_LOAD, 32'd100);
            bus_write(A_CTRL, (32'h1 << 7) | (32'(V_CODE[v]) << 2));
            ticks(V_TICKS[v]);
            bus_read(A_VAL, r);
            chk($sformatf("R3 vector %0d", v), r, 32'(V_EXP[v]));
        end

        // R2 map, reserved bits, clear reads zero, value read-only
        do_reset();
        bus_write(A_VAL, 32'h1234);
        bus_read(A_VAL, r);  chk("R2 value read-only", r, 32'hFFFF);
        bus_write(A_CTRL, 32'h0000_0011 | 32'hFFFF_FE00);
        bus_read(A_CTRL, r); chk("R2 reserved ctrl bits", r, 32'h10);
        // R11 secure-clear stored, no counting
        ticks(2);
        bus_read(A_VAL, r);  chk("R11 secure bit inert", r, 32'hFFFF);
        bus_read(A_CLR, r);  chk("R2 clear reads zero", r, 0);

        // R4 down free-running wrap from 1 with irq
        do_reset();
        bus_write(A_LOAD, 32'd1);
        bus_read(A_VAL, r);  chk("R2 load copies to counter", r, 1);
        bus_write(A_CTRL, 32'h80);
        ticks(1);
        chk("R4 no irq before terminal", {31'b0, irq}, 0);
        ticks(1);
        bus_read(A_VAL, r);  chk("R4 down wrap", r, 32'hFFFF);
        chk("R6 irq on down terminal", {31'b0, irq}, 1);
        ticks(1);
        chk("R6 irq holds", {31'b0, irq}, 1);
        bus_write(A_CLR, 32'h0);
        chk("R6 irq cleared", {31'b0, irq}, 0);

        // R5 up free-running wrap
        do_reset();
        bus_write(A_LOAD, 32'hFFFE);
        bus_write(A_CTRL, 32'h180);
        ticks(2);
        bus_read(A_VAL, r);  chk("R5 up wrap to 0", r, 0);
        chk("R5 irq on up terminal", {31'b0, irq}, 1);

        // R5 up periodic reload
        do_reset();
        bus_write(A_LOAD, 32'hFFFD);
        bus_write(A_CTRL, 32'h1C0);
        ticks(3);
        bus_read(A_VAL, r);  chk("R5 periodic reload", r, 32'hFFFD);

        // R12 prescaler phase restart on field change
        do_reset();
        bus_write(A_LOAD, 32'd100);
        bus_write(A_CTRL, 32'h84);
        ticks(10);
        bus_write(A_CTRL, 32'h88);
        bus_write(A_CTRL, 32'h84);
        ticks(15);
        bus_read(A_VAL, r);  chk("R12 restart, no step yet", r, 100);
        ticks(1);
        bus_read(A_VAL, r);  chk("R12 step after full period", r, 99);

        // R7 watchdog with irq option, up bit ignored
        do_reset();
        bus_write(A_LOAD, 32'd3);
        bus_write(A_CTRL, 32'h122);
        ticks(3);
        bus_read(A_VAL, r);  chk("R7 forced down to 0", r, 0);
        chk("R8 no irq before expiry", {31'b0, irq}, 0);
        ticks(1);
        chk("R8 irq on expiry", {31'b0, irq}, 1);
        chk("R8 no reset pulse with irq option", {31'b0, wdr}, 0);
        bus_read(A_VAL, r);  chk("R7 reload on expiry", r, 3);

        // R10 lock
        bus_write(A_LOAD, 32'd50);
        bus_read(A_LOAD, r); chk("R10 load locked", r, 3);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, r); chk("R10 ctrl locked", r, 32'h122);

        // R9 service before timeout
        bus_write(A_CLR, 32'h0);
        ticks(2);
        bus_read(A_VAL, r);  chk("R9 counting", r, 1);
        bus_write(A_CLR, 32'h5A);
        bus_read(A_VAL, r);  chk("R9 service reload", r, 3);
        chk("R9 service clears irq", {31'b0, irq}, 0);
        ticks(3);
        chk("R9 no expiry after service", {31'b0, irq}, 0);

        // R8 reset option
        do_reset();
        bus_write(A_LOAD, 32'd2);
        bus_write(A_CTRL, 32'h20);
        ticks(2);
        chk("R8 no pulse early", {31'b0, wdr}, 0);
        ticks(1);
        chk("R8 reset pulse", {31'b0, wdr}, 1);
        chk("R8 irq stays low", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'b0, wdr}, 0);

        // R10 reset releases the lock
        do_reset();
        bus_read(A_CTRL, r); chk("R10 reset clears lock", r, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule